// File: doc/BRIEF.md
# Descriptor Chain Context Controller

This block runs one descriptor-driven DMA context of a serial-bus link controller. Software programs a command pointer and sets a run bit through a 32-bit register port. The block then reads descriptor headers from host memory over a request/acknowledge port and decodes each command type. It hands every valid descriptor to a data-mover stub through a request/done handshake. At each block-ending descriptor it follows the branch word, and it stops when the branch carries a zero block count.

The command pointer holds a 16-byte-aligned address in bits 31:4 and a block count (Z) in bits 3:0. A zero count means that no descriptor is waiting. Software appends work by writing a new branch word in memory and then setting wake. On that request the controller reads the branch word of the last block again. A memory error or an unknown command parks the context in a dead state with an event code. Only clearing run releases it.

The walker state machine has six states:
- IDLE: run is clear.
- FETCH: a header read is in flight.
- MOVE: a data-mover handshake is in flight.
- BRANCH: the branch word is being read.
- PARKED: running, but nothing to do.
- DEAD: the context has faulted.

It has these transitions:
- From any state to IDLE when run is clear.
- IDLE to FETCH when the count is nonzero, or IDLE to PARKED when it is zero.
- FETCH to MOVE when the command is valid, or FETCH to DEAD on an error or a bad command.
- MOVE to FETCH for a non-final descriptor, or MOVE to BRANCH for a final one.
- BRANCH to FETCH when the new count is nonzero, BRANCH to PARKED when it is zero, and BRANCH to DEAD on an error.
- PARKED to BRANCH on wake.

Top module: `dma_ctx_ctrl`

## Requirements
- R1: After reset every readback is zero. Register word 0 and word 1 read the control word. Its bits are: run at 15, wake at 12, dead at 11, active at 10, speed at 7:5, event code at 4:0, and every other bit zero. Word 2 reads the command pointer, and word 3 reads zero.
- R2: A write to word 0 sets run for wdata bit 15 and wake for wdata bit 12. A write to word 1 clears the same bits, and clearing run also clears wake. No other field of the control word changes on either write.
- R3: A write takes effect only when all four byte enables are set. A write with any other enable pattern changes nothing.
- R4: Software writes to the command pointer take effect only while run and active are both clear. Otherwise they are ignored.
- R5: Suppose run is set by a write presented at one falling edge, with a nonzero Z. Active then reads 0 one cycle later and 1 two cycles later. At that point mem_req is high and mem_addr equals command pointer bits 31:4 with four zero low bits. With a zero Z, active stays 0 and no memory request is made.
- R6: Header bits 31:28 hold the command code: 0 means more (16 bytes), 2 means immediate (32 bytes) and 1 means last (16 bytes). Each valid descriptor gets exactly one data-mover handshake. After a more or an immediate descriptor, the next header is read 16 or 32 bytes further on.
- R7: After the handshake for a last descriptor, the event code becomes 0x11 and the speed becomes xfer_spd. The branch word at that descriptor's address plus 8 is then read and loaded into the command pointer. A nonzero Z continues at the branch address. A zero Z clears active and parks the context.
- R8: Setting wake while run was already set, with the context parked, re-reads the branch word of the last block. Before any last descriptor has been seen, this is the starting address plus 8. Wake clears once that read completes. A wake write while run is clear is ignored.
- R9: A memory error on any read sets dead, clears active, sets the event code to 0x0E and sets the speed to 0.
- R10: An unknown command code (3 to 15) sets dead, clears active and sets the event code to 0x0F. No data-mover handshake is started for that descriptor.
- R11: Dead stays set for as long as run stays set. Clearing run clears dead and active and keeps the event code. Setting run again restarts the walk from the command pointer.
- R12: A write that clears run mid-chain drops active, mem_req and xfer_req two clock edges after the write is presented.
- R13: mem_req stays high with a stable mem_addr until mem_ack arrives. xfer_req stays high until xfer_done arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_be | input | 4 | Byte enables; only 4'hF writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of the addressed word |
| mem_req | output | 1 | Host memory read request |
| mem_addr | output | 32 | Byte address of the requested quadlet |
| mem_ack | input | 1 | Read complete |
| mem_err | input | 1 | Read failed; valid with mem_ack |
| mem_rdata | input | 32 | Read data; valid with mem_ack |
| xfer_req | output | 1 | Data-mover request for the current descriptor |
| xfer_done | input | 1 | Data-mover finished |
| xfer_spd | input | 3 | Speed reported by the data mover at done |

## Verification
A register write presented at a falling edge is captured at the next rising edge, so its readback is due one cycle later. Run reaches the walker one edge after that, which is why R5 samples active at one and then two falling edges after the write. R12 samples the drop of the requests at the second falling edge after the write. Chain results depend on randomly delayed memory and data-mover responses, so the bench polls the control word until active and wake are both clear. It then compares the whole list of accessed addresses, the handshake count and the final registers against a bench walk of the same memory image.

// File: rtl/dma_ctx_pkg.sv
package dma_ctx_pkg;
    localparam int DW    = 32;
    localparam int SPD_W = 3;
    localparam int EVT_W = 5;
    localparam int CMD_W = 4;
    localparam int STEP_W = 6;

    localparam int BIT_RUN    = 15;
    localparam int BIT_WAKE   = 12;
    localparam int BIT_DEAD   = 11;
    localparam int BIT_ACTIVE = 10;

    localparam logic [CMD_W-1:0] CMD_MORE = 4'd0;
    localparam logic [CMD_W-1:0] CMD_LAST = 4'd1;
    localparam logic [CMD_W-1:0] CMD_IMM  = 4'd2;

    localparam logic [EVT_W-1:0] EVT_DONE   = 5'h11;
    localparam logic [EVT_W-1:0] EVT_MEMERR = 5'h0E;
    localparam logic [EVT_W-1:0] EVT_BADCMD = 5'h0F;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_MOVE, S_BRANCH, S_PARKED, S_DEAD
    } wstate_e;
endpackage

// File: rtl/desc_decode.sv
module desc_decode
    import dma_ctx_pkg::*;
(
    input  logic [CMD_W-1:0]  cmd,
    output logic              is_last,
    output logic              bad,
    output logic [STEP_W-1:0] step
);
    always_comb begin
        is_last = 1'b0;
        bad     = 1'b0;
        step    = STEP_W'(16);
        unique case (cmd)
            CMD_MORE: step = STEP_W'(16);
            CMD_LAST: is_last = 1'b1;
            CMD_IMM:  step = STEP_W'(32);
            default:  bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/ctx_regs.sv
module ctx_regs
    import dma_ctx_pkg::*;
#(
    parameter int RA_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [3:0]       reg_be,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             active,
    input  logic             wake_clr,
    input  logic             cp_load,
    input  logic [DW-1:0]    cp_val,
    input  logic             stat_we,
    input  logic [EVT_W-1:0] stat_evt,
    input  logic [SPD_W-1:0] stat_spd,
    output logic             run,
    output logic             wake,
    output logic [DW-1:0]    cmdptr,
    output logic [EVT_W-1:0] evt,
    output logic [SPD_W-1:0] spd
);
    localparam logic [RA_W-1:0] A_SET = RA_W'(0);
    localparam logic [RA_W-1:0] A_CLR = RA_W'(1);
    localparam logic [RA_W-1:0] A_CP  = RA_W'(2);

    logic full_wr;
    assign full_wr = reg_we && (reg_be == 4'hF);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            wake   <= 1'b0;
            cmdptr <= '0;
            evt    <= '0;
            spd    <= '0;
        end else begin
            if (full_wr && reg_addr == A_SET) begin
                if (reg_wdata[BIT_RUN])           run  <= 1'b1;
                if (reg_wdata[BIT_WAKE] && run)   wake <= 1'b1;
            end
            if (full_wr && reg_addr == A_CLR) begin
                if (reg_wdata[BIT_RUN])  begin run <= 1'b0; wake <= 1'b0; end
                if (reg_wdata[BIT_WAKE]) wake <= 1'b0;
            end
            if (wake_clr) wake <= 1'b0;
            if (full_wr && reg_addr == A_CP && !run && !active)
                cmdptr <= reg_wdata;
            else if (cp_load)
                cmdptr <= cp_val;
            if (stat_we) begin
                evt <= stat_evt;
                spd <= stat_spd;
            end
        end
    end

    // R4
    cmdptr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && reg_addr == A_CP && run && !cp_load) |=> $stable(cmdptr));
endmodule

// File: rtl/desc_walker.sv
module desc_walker
    import dma_ctx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wake,
    input  logic [DW-1:0]    cmdptr,
    output logic             mem_req,
    output logic [DW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [DW-1:0]    mem_rdata,
    output logic             xfer_req,
    input  logic             xfer_done,
    input  logic [SPD_W-1:0] xfer_spd,
    output logic             active,
    output logic             dead,
    output logic             wake_clr,
    output logic             cp_load,
    output logic [DW-1:0]    cp_val,
    output logic             stat_we,
    output logic [EVT_W-1:0] stat_evt,
    output logic [SPD_W-1:0] stat_spd
);
    wstate_e state, nxt;
    logic [DW-1:0]     cur_addr, last_addr;
    logic              last_q;
    logic [STEP_W-1:0] step_q;
    logic              dec_last, dec_bad;
    logic [STEP_W-1:0] dec_step;

    desc_decode u_dec (
        .cmd     (mem_rdata[DW-1 -: CMD_W]),
        .is_last (dec_last),
        .bad     (dec_bad),
        .step    (dec_step)
    );

    always_comb begin
        nxt = state;
        if (!run) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:   nxt = (cmdptr[3:0] != 4'd0) ? S_FETCH : S_PARKED;
                S_FETCH:  if (mem_ack) nxt = (mem_err || dec_bad) ? S_DEAD : S_MOVE;
                S_MOVE:   if (xfer_done) nxt = last_q ? S_BRANCH : S_FETCH;
                S_BRANCH: if (mem_ack)
                              nxt = mem_err ? S_DEAD :
                                    (mem_rdata[3:0] != 4'd0) ? S_FETCH : S_PARKED;
                S_PARKED: if (wake) nxt = S_BRANCH;
                S_DEAD:   nxt = S_DEAD;
                default:  nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            last_addr <= '0;
            last_q    <= 1'b0;
            step_q    <= '0;
        end else begin
            if (state == S_IDLE) begin
                cur_addr  <= {cmdptr[DW-1:4], 4'h0};
                last_addr <= {cmdptr[DW-1:4], 4'h0};
            end
            if (state == S_FETCH && mem_ack) begin
                last_q <= dec_last;
                step_q <= dec_step;
                if (dec_last) last_addr <= cur_addr;
            end
            if (state == S_MOVE && xfer_done && !last_q)
                cur_addr <= cur_addr + DW'(step_q);
            if (state == S_BRANCH && mem_ack && !mem_err)
                cur_addr <= {mem_rdata[DW-1:4], 4'h0};
        end
    end

    always_comb begin
        mem_req  = (state == S_FETCH) || (state == S_BRANCH);
        mem_addr = (state == S_BRANCH) ? last_addr + DW'(8) : cur_addr;
        xfer_req = (state == S_MOVE);
        active   = (state == S_FETCH) || (state == S_MOVE) || (state == S_BRANCH);
        dead     = (state == S_DEAD);
        wake_clr = (state == S_BRANCH) && mem_ack;
        cp_load  = (state == S_BRANCH) && mem_ack && !mem_err;
        cp_val   = mem_rdata;
        stat_we  = 1'b0;
        stat_evt = EVT_DONE;
        stat_spd = xfer_spd;
        if (state == S_MOVE && xfer_done && last_q) begin
            stat_we = 1'b1;
        end else if (mem_req && mem_ack && mem_err) begin
            stat_we  = 1'b1;
            stat_evt = EVT_MEMERR;
            stat_spd = '0;
        end else if (state == S_FETCH && mem_ack && dec_bad) begin
            stat_we  = 1'b1;
            stat_evt = EVT_BADCMD;
            stat_spd = '0;
        end
    end

    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && run) |=> (mem_req && $stable(mem_addr)));
    // R13
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done && run) |=> xfer_req);
    // R11
    dead_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dead && !run) |=> (!dead && !active));
    // R5
    active_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(run));
endmodule

// File: rtl/dma_ctx_ctrl.sv
module dma_ctx_ctrl
    import dma_ctx_pkg::*;
#(
    parameter int RA_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [3:0]       reg_be,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             mem_req,
    output logic [DW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [DW-1:0]    mem_rdata,
    output logic             xfer_req,
    input  logic             xfer_done,
    input  logic [SPD_W-1:0] xfer_spd
);
    logic             run, wake, active, dead, wake_clr, cp_load, stat_we;
    logic [DW-1:0]    cmdptr, cp_val;
    logic [EVT_W-1:0] evt, stat_evt;
    logic [SPD_W-1:0] spd, stat_spd;
    logic [DW-1:0]    ctl_word;

    ctx_regs #(.RA_W(RA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .active(active),
        .wake_clr(wake_clr), .cp_load(cp_load), .cp_val(cp_val),
        .stat_we(stat_we), .stat_evt(stat_evt), .stat_spd(stat_spd),
        .run(run), .wake(wake), .cmdptr(cmdptr), .evt(evt), .spd(spd)
    );

    desc_walker u_walk (
        .clk(clk), .rst_n(rst_n), .run(run), .wake(wake), .cmdptr(cmdptr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .xfer_req(xfer_req),
        .xfer_done(xfer_done), .xfer_spd(xfer_spd), .active(active),
        .dead(dead), .wake_clr(wake_clr), .cp_load(cp_load), .cp_val(cp_val),
        .stat_we(stat_we), .stat_evt(stat_evt), .stat_spd(stat_spd)
    );

    always_comb begin
        ctl_word = '0;
        ctl_word[BIT_RUN]    = run;
        ctl_word[BIT_WAKE]   = wake;
        ctl_word[BIT_DEAD]   = dead;
        ctl_word[BIT_ACTIVE] = active;
        ctl_word[EVT_W+SPD_W-1:EVT_W] = spd;
        ctl_word[EVT_W-1:0]  = evt;
        unique case (reg_addr)
            RA_W'(0), RA_W'(1): reg_rdata = ctl_word;
            RA_W'(2):           reg_rdata = cmdptr;
            default:            reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/sim_dma_ctx_ctrl.sv
module sim_dma_ctx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [3:0]  reg_be = 4'hF;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, xfer_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0, mem_err = 1'b0, xfer_done = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  xfer_spd = 3'd0;

    int total = 0, bad = 0, cyc = 0;
    logic [31:0] mem [64];
    bit          emap [64];
    logic [7:0]  mlog [64];
    int nlog = 0, nx = 0, hold_bad = 0;
    int mdly = 0, xdly = 0;
    bit pend = 0, xpend = 0;
    logic [31:0] paddr = '0;

    logic [7:0] elog [64];
    int en, ex;
    bit e_dead;
    logic [4:0] e_evt, m_evt;
    logic [2:0] e_spd, m_spd;
    logic [31:0] e_cp;

    dma_ctx_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .xfer_req(xfer_req),
        .xfer_done(xfer_done), .xfer_spd(xfer_spd)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ctl(bit r, bit w, bit d, bit a, logic [2:0] s, logic [4:0] e);
        return {16'h0, r, 2'b00, w, d, a, 2'b00, s, e};
    endfunction

    // memory and data-mover stubs with random response delay
    always @(negedge clk) begin
        if (mem_req && pend && mem_addr != paddr) hold_bad++;
        if (mem_req && mdly == 0) begin
            mem_ack = 1'b1;
            mem_rdata = mem[mem_addr[7:2]];
            mem_err = emap[mem_addr[7:2]];
            if (nlog < 64) mlog[nlog] = mem_addr[7:0];
            nlog++;
            mdly = int'($urandom % 3);
            pend = 1'b0;
        end else if (mem_req) begin
            mem_ack = 1'b0; mem_err = 1'b0;
            mdly--; pend = 1'b1; paddr = mem_addr;
        end else begin
            mem_ack = 1'b0; mem_err = 1'b0; pend = 1'b0;
        end
        if (xfer_req && xdly == 0) begin
            xfer_done = 1'b1; nx++; xdly = int'($urandom % 3); xpend = 1'b0;
        end else if (xfer_req) begin
            xfer_done = 1'b0; xdly--; xpend = 1'b1;
        end else begin
            if (xpend) hold_bad++;
            xfer_done = 1'b0; xpend = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish (got cycle %0d, expected less)", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3000; k++) begin
            rd(2'd0, v);
            if (!v[10] && !v[12]) break;
        end
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 64; i++) begin mem[i] = '0; emap[i] = 1'b0; end
    endtask

    task automatic walk(logic [31:0] start, logic [2:0] sp);
        logic [7:0] cur, ba;
        logic [3:0] cmd;
        logic [31:0] br;
        en = 0; ex = 0; e_dead = 0; e_evt = m_evt; e_spd = m_spd; e_cp = start;
        cur = {start[7:4], 4'h0};
        for (int k = 0; k < 40; k++) begin
            elog[en] = cur; en++;
            if (emap[cur[7:2]]) begin e_dead = 1; e_evt = 5'h0E; e_spd = 0; break; end
            cmd = mem[cur[7:2]][31:28];
            if (cmd > 4'd2) begin e_dead = 1; e_evt = 5'h0F; e_spd = 0; break; end
            ex++;
            if (cmd == 4'd1) begin
                e_evt = 5'h11; e_spd = sp;
                ba = cur + 8'd8;
                elog[en] = ba; en++;
                if (emap[ba[7:2]]) begin e_dead = 1; e_evt = 5'h0E; e_spd = 0; break; end
                br = mem[ba[7:2]]; e_cp = br;
                if (br[3:0] == 4'd0) break;
                cur = {br[7:4], 4'h0};
            end else begin
                cur = cur + ((cmd == 4'd2) ? 8'd32 : 8'd16);
            end
        end
        m_evt = e_evt; m_spd = e_spd;
    endtask

    task automatic chk_log(string tag);
        int ok = (nlog == en);
        for (int i = 0; i < en && ok != 0; i++) if (mlog[i] !== elog[i]) ok = 0;
        chk({tag, " access count"}, nlog, en);
        chk({tag, " access sequence"}, ok, 1);
    endtask

    task automatic gen();
        logic [7:0] pos;
        logic [3:0] c;
        clr_mem();
        for (int blk = 0; blk < 2; blk++) begin
            int n = int'($urandom % 4);
            pos = 8'(blk * 128);
            for (int i = 0; i < n; i++) begin
                c = ($urandom % 6 == 0) ? 4'h9 : (($urandom % 2) != 0 ? 4'h2 : 4'h0);
                mem[pos[7:2]] = {c, 12'h0, 16'($urandom)};
                pos = pos + ((c == 4'h2) ? 8'd32 : 8'd16);
            end
            mem[pos[7:2]] = {4'h1, 28'h0};
            pos = pos + 8'd8;
            mem[pos[7:2]] = (blk == 0 && ($urandom % 2) != 0) ? 32'h81 : 32'hA0;
        end
        if ($urandom % 8 == 0) emap[$urandom % 64] = 1'b1;
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd11));
        clr_mem();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        rd(2'd0, v); chk("R1 reset control word", v, 0);
        rd(2'd2, v); chk("R1 reset command pointer", v, 0);
        rd(2'd3, v); chk("R1 word 3 reads zero", v, 0);

        wr(2'd2, 32'h41, 4'h3);
        rd(2'd2, v); chk("R3 partial write ignored", v, 0);
        wr(2'd2, 32'h40);
        rd(2'd2, v); chk("R4 idle pointer write", v, 32'h40);

        wr(2'd0, 32'h1000);
        rd(2'd0, v); chk("R8 wake ignored without run", v, 0);

        nlog = 0;
        wr(2'd0, 32'h8000);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R5 zero count stays inactive", v, ctl(1,0,0,0,0,0));
        chk("R5 zero count no fetch", nlog, 0);
        wr(2'd2, 32'h99);
        rd(2'd2, v); chk("R4 pointer locked while running", v, 32'h40);

        mem[32'h48 >> 2] = 32'h0;
        wr(2'd0, 32'h1000);
        wait_idle();
        chk("R8 wake reads start+8", (nlog == 1 && mlog[0] == 8'h48) ? 1 : 0, 1);
        rd(2'd0, v); chk("R8 wake cleared after read", v, ctl(1,0,0,0,0,0));
        rd(2'd2, v); chk("R7 branch loaded", v, 0);

        mem[32'h48 >> 2] = 32'h61;
        mem[32'h60 >> 2] = {4'h1, 28'h0};
        mem[32'h68 >> 2] = 32'h0;
        xfer_spd = 3'd5; nlog = 0;
        wr(2'd0, 32'h1000);
        wait_idle();
        chk("R7 wake chain accesses",
            (nlog == 3 && mlog[0] == 8'h48 && mlog[1] == 8'h60 && mlog[2] == 8'h68) ? 1 : 0, 1);
        rd(2'd0, v); chk("R7 completion code and speed", v, ctl(1,0,0,0,3'd5,5'h11));

        wr(2'd1, 32'h8000);
        rd(2'd0, v); chk("R2 clear run keeps status", v, ctl(0,0,0,0,3'd5,5'h11));
        wr(2'd0, 32'h9000);
        rd(2'd0, v); chk("R2 set run, wake needs prior run", v, ctl(1,0,0,0,3'd5,5'h11));
        wr(2'd1, 32'h8000);

        clr_mem();
        mem[32'h80 >> 2] = {4'h0, 28'h0};
        mem[32'h90 >> 2] = {4'h2, 28'h0};
        mem[32'hB0 >> 2] = {4'h1, 28'h0};
        mem[32'hB8 >> 2] = 32'h0;
        xfer_spd = 3'd2;
        wr(2'd2, 32'h81);
        nlog = 0; nx = 0;
        wr(2'd0, 32'h8000);
        #1 chk("R5 active low one cycle after write", reg_rdata[10], 0);
        @(negedge clk);
        #1 chk("R5 active two cycles after write", reg_rdata[10], 1);
        chk("R5 first fetch request", mem_req, 1);
        chk("R5 first fetch address", mem_addr, 32'h80);
        wait_idle();
        chk("R6 stride sequence",
            (nlog == 4 && mlog[0] == 8'h80 && mlog[1] == 8'h90 && mlog[2] == 8'hB0 && mlog[3] == 8'hB8) ? 1 : 0, 1);
        chk("R6 one handshake per descriptor", nx, 3);
        rd(2'd0, v); chk("R7 parked after zero branch", v, ctl(1,0,0,0,3'd2,5'h11));
        wr(2'd1, 32'h8000);

        clr_mem();
        wr(2'd2, 32'h01);
        wr(2'd0, 32'h8000);
        repeat (7) @(negedge clk);
        wr(2'd1, 32'h8000);
        @(negedge clk);
        #1 chk("R12 active drops", reg_rdata[10], 0);
        chk("R12 mem_req drops", mem_req, 0);
        chk("R12 xfer_req drops", xfer_req, 0);

        clr_mem();
        mem[32'h10 >> 2] = {4'h1, 28'h0};
        emap[32'h10 >> 2] = 1'b1;
        nlog = 0;
        wr(2'd0, 32'h8000);
        wait_idle();
        rd(2'd0, v); chk("R9 memory error parks dead", v, ctl(1,0,1,0,0,5'h0E));
        repeat (10) @(negedge clk);
        rd(2'd0, v); chk("R11 dead persists with run", v, ctl(1,0,1,0,0,5'h0E));
        wr(2'd1, 32'h8000);
        rd(2'd0, v); chk("R11 clear run clears dead", v, ctl(0,0,0,0,0,5'h0E));
        emap[32'h10 >> 2] = 1'b0;
        xfer_spd = 3'd6;
        wr(2'd0, 32'h8000);
        wait_idle();
        rd(2'd0, v); chk("R11 restart completes", v, ctl(1,0,0,0,3'd6,5'h11));
        wr(2'd1, 32'h8000);

        clr_mem();
        mem[32'h20 >> 2] = {4'h7, 28'h0};
        wr(2'd2, 32'h21);
        nx = 0;
        wr(2'd0, 32'h8000);
        wait_idle();
        rd(2'd0, v); chk("R10 bad command parks dead", v, ctl(1,0,1,0,0,5'h0F));
        chk("R10 no handshake for bad command", nx, 0);
        wr(2'd1, 32'h8000);

        m_evt = 5'h0F; m_spd = 3'd0;
        for (int it = 0; it < 12; it++) begin
            gen();
            xfer_spd = 3'($urandom);
            wr(2'd2, 32'h01);
            walk(32'h01, xfer_spd);
            nlog = 0; nx = 0;
            wr(2'd0, 32'h8000);
            wait_idle();
            chk_log("R6 random chain");
            chk("R6 random handshakes", nx, ex);
            rd(2'd0, v); chk("R7 R9 R10 random status", v, ctl(1,0,e_dead,0,e_spd,e_evt));
            rd(2'd2, v); chk("R7 random pointer", v, e_cp);
            wr(2'd1, 32'h8000);
            repeat (2) @(negedge clk);
        end

        chk("R13 handshake hold violations", hold_bad, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule